// File: doc/BRIEF.md
# Branch Way-History Table

This block sits next to a branch target buffer and remembers, for each buffer entry, which instruction-cache way held each of the next few cache lines fetched after that branch. Every entry has two histories: one for the path followed when the branch is taken, and one for the fall-through path. On a buffer hit, the fetch unit supplies the entry index and the predicted direction. In the same cycle the table returns the history for that direction and a flag that says whether the history can be trusted. When the flag is set, the cache can enable only the recorded way and skip the tag compare.

A recorded history is written back as one group and marks that group trustworthy. A cache miss or a buffer replacement may move lines, so either one wipes every flag in the table at once. A write to an entry other than the one being looked up shares the buffer's access slot and blocks that lookup for one cycle. A flush does the same. The stall output reports these cycles.

Top module: `wayHistTable`

## Requirements
- R1: After reset every flag is clear, so `rdValid` is 0 for every index and direction.
- R2: The read is combinational. `lookupTaken`=1 selects the taken-path group and 0 selects the fall-through group. The two groups of one entry are stored independently.
- R3: A write with no flush in the same cycle stores `wrPtrs` into group (`wrIdx`, `wrTaken`) and sets its flag. From the next cycle a lookup of that group returns `rdValid`=1 and exactly those bits, and the other group is unchanged. Pointer k (k=0 is the first line after the branch) occupies bits [k*log2(WAYS) +: log2(WAYS)].
- R4: A cycle with `cacheMiss` or `btbReplace` high clears every flag from the next cycle on.
- R5: When a write and a flush arrive in the same cycle, the flush wins and the written group reads back invalid.
- R6: `stall` is 1 exactly in cycles that have a flush request, or a write together with a lookup whose index differs from `wrIdx`.
- R7: While `stall` is 1, `rdValid` is 0.
- R8: A write to the same index that is being looked up does not stall. That cycle's read returns the contents held before the write.
- R9: With `lookupValid` low, `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Branch buffer hit this cycle |
| lookupIdx | input | IDXW | Index of the hit entry |
| lookupTaken | input | 1 | Predicted direction (1 = taken) |
| rdPtrs | output | PTRS*log2(WAYS) | Selected way-pointer group |
| rdValid | output | 1 | Selected group is usable this cycle |
| wrEn | input | 1 | Store a recorded group |
| wrIdx | input | IDXW | Entry to write |
| wrTaken | input | 1 | Group to write (1 = taken path) |
| wrPtrs | input | PTRS*log2(WAYS) | Recorded way pointers |
| cacheMiss | input | 1 | Instruction cache miss, flushes all flags |
| btbReplace | input | 1 | Branch buffer replacement, flushes all flags |
| stall | output | 1 | Lookup blocked this cycle |

## Verification
The hardest cases to reach are the ones where several events land in the same cycle. Examples are a write plus a flush, a write plus a lookup of the same entry, and a write plus a lookup of another entry. In each, the priority between stall, flush and the read-before-write order decides the result. Directed steps place each of these collisions on purpose. A long random phase then confines indices to a few entries and raises flush rarely. This keeps valid histories present often enough that hits, overwrites and conflicts all recur. A reference model of flags and groups is compared against the outputs on every cycle.

// File: rtl/wht_pkg.sv
package wht_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrGo;      // commit the write this cycle
    logic flushAll;  // clear every valid flag
    logic blockRead; // suppress the lookup result
  } whtStrobes_t;
endpackage

// File: rtl/wht_ctrl.sv
module wht_ctrl #(
  parameter int IDXW = 4
) (
  input  logic               lookupValid,
  input  logic [IDXW-1:0]    lookupIdx,
  input  logic               wrEn,
  input  logic [IDXW-1:0]    wrIdx,
  input  logic               cacheMiss,
  input  logic               btbReplace,
  output wht_pkg::whtStrobes_t strb,
  output logic               stall
);
  logic flushReq;
  logic portConflict;

  always_comb begin
    flushReq     = cacheMiss | btbReplace;
    portConflict = wrEn & lookupValid & (wrIdx != lookupIdx);
    stall          = flushReq | portConflict;
    strb.flushAll  = flushReq;
    strb.wrGo      = wrEn & ~flushReq;
    strb.blockRead = stall;
  end
endmodule

// File: rtl/wht_data.sv
module wht_data #(
  parameter int ENTRIES = 16,
  parameter int IDXW    = 4,
  parameter int GRPW    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wht_pkg::whtStrobes_t strb,
  input  logic [IDXW-1:0]      wrIdx,
  input  logic                 wrTaken,
  input  logic [GRPW-1:0]      wrPtrs,
  input  logic                 lookupValid,
  input  logic [IDXW-1:0]      lookupIdx,
  input  logic                 lookupTaken,
  output logic [GRPW-1:0]      rdPtrs,
  output logic                 rdValid
);
  localparam int SLOTS = ENTRIES * 2;
  localparam int SLOTW = IDXW + 1;

  logic [GRPW-1:0]  ptrMem [SLOTS];
  logic [SLOTS-1:0] vldMem;
  logic [SLOTS-1:0] slotWe;
  logic [SLOTW-1:0] wrSlot;
  logic [SLOTW-1:0] rdSlot;

  assign wrSlot = {wrIdx, wrTaken};
  assign rdSlot = {lookupIdx, lookupTaken};

  // One write-enable decoder per slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_slotDec
    assign slotWe[s] = strb.wrGo && (wrSlot == SLOTW'(s));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldMem <= '0;
      for (int s = 0; s < SLOTS; s++) ptrMem[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (strb.flushAll)  vldMem[s] <= 1'b0;
        else if (slotWe[s]) vldMem[s] <= 1'b1;
        if (slotWe[s])      ptrMem[s] <= wrPtrs;
      end
    end
  end

  // Same-cycle read of registered state
  always_comb begin
    rdPtrs  = ptrMem[rdSlot];
    rdValid = lookupValid & ~strb.blockRead & vldMem[rdSlot];
  end
endmodule

// File: rtl/wayHistTable.sv
module wayHistTable #(
  parameter int ENTRIES = 16,
  parameter int PTRS    = 4,
  parameter int WAYS    = 4,
  localparam int WPW    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int GRPW   = PTRS * WPW,
  localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lookupValid,
  input  logic [IDXW-1:0] lookupIdx,
  input  logic            lookupTaken,
  output logic [GRPW-1:0] rdPtrs,
  output logic            rdValid,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic            wrTaken,
  input  logic [GRPW-1:0] wrPtrs,
  input  logic            cacheMiss,
  input  logic            btbReplace,
  output logic            stall
);
  wht_pkg::whtStrobes_t strb;

  wht_ctrl #(.IDXW(IDXW)) ctrl_i (
    .lookupValid(lookupValid), .lookupIdx(lookupIdx),
    .wrEn(wrEn), .wrIdx(wrIdx),
    .cacheMiss(cacheMiss), .btbReplace(btbReplace),
    .strb(strb), .stall(stall)
  );

  wht_data #(.ENTRIES(ENTRIES), .IDXW(IDXW), .GRPW(GRPW)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrIdx(wrIdx), .wrTaken(wrTaken), .wrPtrs(wrPtrs),
    .lookupValid(lookupValid), .lookupIdx(lookupIdx), .lookupTaken(lookupTaken),
    .rdPtrs(rdPtrs), .rdValid(rdValid)
  );
endmodule

// File: rtl/wht_checker.sv
module wht_checker #(
  parameter int IDXW = 4,
  parameter int GRPW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            lookupValid,
  input logic [IDXW-1:0] lookupIdx,
  input logic            lookupTaken,
  input logic [GRPW-1:0] rdPtrs,
  input logic            rdValid,
  input logic            wrEn,
  input logic [IDXW-1:0] wrIdx,
  input logic            wrTaken,
  input logic [GRPW-1:0] wrPtrs,
  input logic            cacheMiss,
  input logic            btbReplace,
  input logic            stall
);
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !cacheMiss && !btbReplace) |=>
      (!(lookupValid && !stall && lookupIdx == $past(wrIdx) && lookupTaken == $past(wrTaken))
       || (rdValid && rdPtrs == $past(wrPtrs)))); // R3
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cacheMiss || btbReplace) |=> !rdValid); // R4
  AST_FLUSH_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cacheMiss) |=> !rdValid); // R5
  AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (cacheMiss || btbReplace) |-> stall); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !rdValid); // R7
  AST_SAME_ENTRY_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && lookupValid && wrIdx == lookupIdx && !cacheMiss && !btbReplace) |-> !stall); // R8
  AST_NO_LOOKUP_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !rdValid); // R9
endmodule

bind wayHistTable wht_checker #(.IDXW(IDXW), .GRPW(GRPW)) chk_i (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupIdx(lookupIdx),
  .lookupTaken(lookupTaken), .rdPtrs(rdPtrs), .rdValid(rdValid), .wrEn(wrEn),
  .wrIdx(wrIdx), .wrTaken(wrTaken), .wrPtrs(wrPtrs), .cacheMiss(cacheMiss),
  .btbReplace(btbReplace), .stall(stall)
);

// File: tb/wayHistTable_tb_top.sv
`timescale 1ns/1ps
module wayHistTable_tb_top;
  localparam int ENTRIES = 16;
  localparam int IDXW = 4;
  localparam int GRPW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 0, lookupTaken = 0, wrEn = 0, wrTaken = 0;
  logic cacheMiss = 0, btbReplace = 0;
  logic [IDXW-1:0] lookupIdx = '0, wrIdx = '0;
  logic [GRPW-1:0] wrPtrs = '0;
  logic [GRPW-1:0] rdPtrs;
  logic rdValid, stall;

  int checks = 0, fails = 0;
  bit done = 0;
  int refPtr [ENTRIES*2];
  bit refVld [ENTRIES*2];

  always #4 clk = ~clk; // 125 MHz

  wayHistTable dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupIdx(lookupIdx),
    .lookupTaken(lookupTaken), .rdPtrs(rdPtrs), .rdValid(rdValid), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrTaken(wrTaken), .wrPtrs(wrPtrs), .cacheMiss(cacheMiss),
    .btbReplace(btbReplace), .stall(stall)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, compare against the model, then update it.
  task automatic step(input string tag, input bit lv, input int li, input bit lt,
                      input bit we, input int wi, input bit wt, input int wp,
                      input bit cm, input bit br);
    bit eStall, eVld;
    int slot;
    @(negedge clk);
    lookupValid = lv; lookupIdx = IDXW'(li); lookupTaken = lt;
    wrEn = we; wrIdx = IDXW'(wi); wrTaken = wt; wrPtrs = GRPW'(wp);
    cacheMiss = cm; btbReplace = br;
    #1;
    slot  = li * 2 + int'(lt);
    eStall = cm || br || (we && lv && wi != li);
    eVld   = lv && !eStall && refVld[slot];
    check(tag, "stall", int'(stall), int'(eStall));
    check(tag, "rdValid", int'(rdValid), int'(eVld));
    if (eVld) check(tag, "rdPtrs", int'(rdPtrs), refPtr[slot]);
    @(posedge clk);
    if (cm || br) begin
      for (int s = 0; s < ENTRIES*2; s++) refVld[s] = 0;
    end else if (we) begin
      refPtr[wi*2 + int'(wt)] = wp;
      refVld[wi*2 + int'(wt)] = 1;
    end
  endtask

  task automatic idleRead(input string tag, input int li, input bit lt);
    step(tag, 1, li, lt, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < ENTRIES*2; s++) begin refVld[s] = 0; refPtr[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: every slot invalid after reset
    for (int e = 0; e < ENTRIES; e++) begin
      idleRead("R1", e, 0);
      idleRead("R1", e, 1);
    end
    // R2 R3: separate groups per direction, pointer k at bits [2k+:2]
    step("R3", 0, 0, 0, 1, 3, 1, 8'b11_10_01_00, 0, 0);
    step("R3", 0, 0, 0, 1, 3, 0, 8'b00_01_10_11, 0, 0);
    idleRead("R2", 3, 1);
    idleRead("R2", 3, 0);
    idleRead("R2", 4, 1);
    // R6 R7: write elsewhere blocks the lookup
    step("R6", 1, 3, 1, 1, 5, 0, 8'h5A, 0, 0);
    step("R7", 1, 3, 0, 1, 9, 1, 8'hC3, 0, 0);
    idleRead("R3", 5, 0);
    // R8: same-entry write does not stall and reads old data
    step("R8", 1, 3, 1, 1, 3, 1, 8'h99, 0, 0);
    idleRead("R8", 3, 1);
    // R9: no lookup, no hit
    step("R9", 0, 3, 1, 0, 0, 0, 0, 0, 0);
    // R4: flush by cache miss and by replacement
    step("R4", 1, 3, 1, 0, 0, 0, 0, 1, 0);
    idleRead("R4", 3, 1);
    idleRead("R4", 5, 0);
    step("R3", 0, 0, 0, 1, 7, 0, 8'h3C, 0, 0);
    idleRead("R3", 7, 0);
    step("R4", 1, 7, 0, 0, 0, 0, 0, 0, 1);
    idleRead("R4", 7, 0);
    // R5: write and flush together, flush wins
    step("R5", 0, 0, 0, 1, 2, 1, 8'hFF, 1, 0);
    idleRead("R5", 2, 1);
    step("R5", 0, 0, 0, 1, 2, 0, 8'hEE, 0, 1);
    idleRead("R5", 2, 0);
    // Random mix on a few entries
    for (int i = 0; i < 3000; i++) begin
      bit lv = ($urandom % 4) != 0;
      bit we = ($urandom % 3) == 0;
      bit cm = ($urandom % 40) == 0;
      bit br = ($urandom % 60) == 0;
      step("R2", lv, $urandom % 4, $urandom % 2, we, $urandom % 4,
           $urandom % 2, $urandom % 256, cm, br);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule